// File: doc/BRIEF.md
# AXI Bus Utilization and Read Latency Monitor

A passive observer for one AXI4 memory port, clocked in the core clock domain. It watches only the valid/ready pairs of the read-address, write-data and read-data channels and drives nothing onto the bus. It counts completed write-data and read-data handshakes. It counts elapsed cycles, starting from the first cycle on which a request is presented. From those counts it derives a utilization percentage, rescaled for a double-data-rate memory that runs at a different clock from the core.

Alongside utilization it measures read latency. The cycle of each read-address handshake is stamped into a small in-order queue. The latency is the distance from that stamp to the first cycle on which read data is offered for that request. Only the smallest latency seen is kept. A run input pauses and resumes measurement. A clear input restarts a measurement window from scratch.

Top module: `axi_perf_mon`

## Requirements
- R1: While `run_i` is high, `wr_beats_o` increments by one after every cycle with `w_valid_i` and `w_ready_i` both high; a cycle with only one of them high leaves it unchanged.
- R2: While `run_i` is high, `rd_beats_o` increments by one after every cycle with `r_valid_i` and `r_ready_i` both high; `r_valid_i` alone does not count.
- R3: `cycles_o` stays 0 until the first cycle with `run_i` high and either `ar_valid_i` or `w_valid_i` high. That cycle and every later cycle with `run_i` high each add one. `r_valid_i` alone does not open the window.
- R4: `eff_pct_o` equals floor((wr_beats + rd_beats) × 200 × CORE_MHZ / (cycles × MEM_MHZ)), clipped to 2^EFF_W−1, and is 0 while `cycles_o` is 0. It reflects the counters within 2×(NUM_W+2) cycles after they settle, where NUM_W = CNT_W + 1 + ceil(log2(200×CORE_MHZ+1)).
- R5: Each read request returns exactly one data beat, in request order. Its latency is the number of cycles from its read-address handshake cycle to the first cycle `r_valid_i` is high while it is the oldest pending request, whether or not `r_ready_i` is high in that cycle.
- R6: `min_lat_o` is all ones after reset and after a clear. It changes only when a new latency is strictly smaller than its current value.
- R7: At most FIFO_DEPTH (8) requests are tracked. A read-address handshake that arrives while 8 are pending, or while an earlier untracked request is still outstanding, yields no latency sample. Its data beat consumes it, so tracking of later requests stays aligned.
- R8: A cycle with `clear_i` high sets `wr_beats_o`, `rd_beats_o`, `cycles_o` and `eff_pct_o` to 0 and `min_lat_o` to all ones at the next edge. It also discards pending requests and closes the window so that a new first request is needed.
- R9: The three counters saturate at 2^CNT_W−1 and never wrap.
- R10: While `run_i` is low, the counters do not change, the window does not open and `min_lat_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of all measurements |
| run_i | input | 1 | Measurement enable |
| ar_valid_i | input | 1 | Observed read-address valid |
| ar_ready_i | input | 1 | Observed read-address ready |
| w_valid_i | input | 1 | Observed write-data valid |
| w_ready_i | input | 1 | Observed write-data ready |
| r_valid_i | input | 1 | Observed read-data valid |
| r_ready_i | input | 1 | Observed read-data ready |
| wr_beats_o | output | CNT_W | Accepted write-data beats |
| rd_beats_o | output | CNT_W | Completed read-data beats |
| cycles_o | output | CNT_W | Cycles since the window opened |
| eff_pct_o | output | EFF_W | Clock-ratio-scaled utilization, percent |
| min_lat_o | output | LAT_W | Smallest read latency, core cycles |

## Verification
A stuck or mis-armed window flag appears at once as a nonzero or frozen `cycles_o` on the very next cycle. Because the percentage is rederived continuously from the counters, a corrupt divider state shows in `eff_pct_o` within two division passes. A queue that loses alignment after an untracked request reports a latency belonging to a different request, so `min_lat_o` moves to a value the stimulus cannot produce. That error appears on the first read after the overflow. Counter wrap appears as a sudden drop on the cycle after the maximum.

// File: rtl/axi_perf_pkg.sv
package axi_perf_pkg;

  // 2x for double data rate, 100x for percent
  localparam int unsigned PCT_SCALE = 200;

  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_BUSY = 1'b1
  } div_state_e;

endpackage

// File: rtl/perf_sat_cnt.sv
module perf_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/perf_ts_fifo.sv
module perf_ts_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic         full_o,
  output logic [W-1:0] head_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W:0]   FULL_CNT = (PTR_W+1)'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [PTR_W:0]   cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);

endmodule

// File: rtl/perf_div.sv
module perf_div import axi_perf_pkg::*; #(
  parameter int unsigned NUM_W = 48,
  parameter int unsigned DEN_W = 42
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);

  localparam int unsigned STEP_W = $clog2(NUM_W + 1);

  div_state_e        state_q;
  logic [NUM_W-1:0]  num_q;
  logic [DEN_W-1:0]  den_q;
  logic [DEN_W-1:0]  rem_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  logic [DEN_W:0]    rem_sh;
  logic [DEN_W:0]    rem_sub;
  logic              q_bit;

  // restoring division, one quotient bit per cycle, quotient shifts into num_q
  always_comb begin
    rem_sh  = {rem_q, num_q[NUM_W-1]};
    q_bit   = (rem_sh >= {1'b0, den_q});
    rem_sub = q_bit ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      num_q   <= '0;
      den_q   <= '0;
      rem_q   <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else if (clr_i) begin
      state_q <= DIV_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        DIV_IDLE: if (start_i) begin
          num_q   <= num_i;
          den_q   <= den_i;
          rem_q   <= '0;
          step_q  <= STEP_W'(NUM_W);
          state_q <= DIV_BUSY;
        end
        DIV_BUSY: begin
          num_q  <= {num_q[NUM_W-2:0], q_bit};
          rem_q  <= rem_sub[DEN_W-1:0];
          step_q <= step_q - 1'b1;
          if (step_q == STEP_W'(1)) begin
            state_q <= DIV_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == DIV_BUSY);
  assign done_o = done_q;
  assign quot_o = num_q;

  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_start_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !clr_i) |=> busy_o);

endmodule

// File: rtl/perf_lat_track.sv
module perf_lat_track #(
  parameter int unsigned LAT_W = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             ar_hs_i,
  input  logic             r_valid_i,
  input  logic             r_hs_i,
  output logic [LAT_W-1:0] min_lat_o
);

  localparam logic [LAT_W-1:0] ONES = '1;

  logic [LAT_W-1:0] ts_q;
  logic [LAT_W-1:0] head_ts;
  logic [LAT_W-1:0] lat;
  logic [LAT_W-1:0] min_q;
  logic [LAT_W-1:0] skip_q;
  logic             head_seen_q;
  logic             empty, full;
  logic             push, pop, skip_inc, skip_dec, measure;

  // untracked requests block pushes until drained, keeping order intact
  assign push     = ar_hs_i && !full && (skip_q == '0);
  assign skip_inc = ar_hs_i && !push;
  assign pop      = r_hs_i && !empty;
  assign skip_dec = r_hs_i && empty && (skip_q != '0);
  assign measure  = r_valid_i && !empty && !head_seen_q;
  assign lat      = ts_q - head_ts;

  perf_ts_fifo #(
    .DEPTH (DEPTH),
    .W     (LAT_W)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .push_i  (push),
    .data_i  (ts_q),
    .pop_i   (pop),
    .empty_o (empty),
    .full_o  (full),
    .head_o  (head_ts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q      <= '0;
      head_seen_q <= 1'b0;
      min_q       <= ONES;
    end else if (clr_i) begin
      skip_q      <= '0;
      head_seen_q <= 1'b0;
      min_q       <= ONES;
    end else begin
      if (skip_inc && !skip_dec && skip_q != ONES) skip_q <= skip_q + 1'b1;
      else if (skip_dec && !skip_inc)              skip_q <= skip_q - 1'b1;

      if (pop)          head_seen_q <= 1'b0;
      else if (measure) head_seen_q <= 1'b1;

      if (measure && en_i && lat < min_q) min_q <= lat;
    end
  end

  assign min_lat_o = min_q;

  assert_min_monotone_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> min_q <= $past(min_q));

  assert_min_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(min_q));

endmodule

// File: rtl/axi_perf_mon.sv
module axi_perf_mon import axi_perf_pkg::*; #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned LAT_W      = 16,
  parameter int unsigned EFF_W      = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CORE_MHZ   = 250,
  parameter int unsigned MEM_MHZ    = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             ar_valid_i,
  input  logic             ar_ready_i,
  input  logic             w_valid_i,
  input  logic             w_ready_i,
  input  logic             r_valid_i,
  input  logic             r_ready_i,
  output logic [CNT_W-1:0] wr_beats_o,
  output logic [CNT_W-1:0] rd_beats_o,
  output logic [CNT_W-1:0] cycles_o,
  output logic [EFF_W-1:0] eff_pct_o,
  output logic [LAT_W-1:0] min_lat_o
);

  localparam int unsigned SCALE   = PCT_SCALE * CORE_MHZ;
  localparam int unsigned SCALE_W = $clog2(SCALE + 1);
  localparam int unsigned NUM_W   = CNT_W + 1 + SCALE_W;
  localparam int unsigned DEN_W   = CNT_W + $clog2(MEM_MHZ + 1);
  localparam int unsigned N_CNT   = 3;
  localparam int unsigned IDX_WR  = 0;
  localparam int unsigned IDX_RD  = 1;
  localparam int unsigned IDX_CY  = 2;
  localparam logic [NUM_W-1:0] EFF_CAP = NUM_W'({EFF_W{1'b1}});

  logic             win_q;
  logic             trigger;
  logic [N_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt [N_CNT];

  logic [CNT_W:0]   beat_sum;
  logic [NUM_W-1:0] div_num;
  logic [DEN_W-1:0] div_den;
  logic             div_start, div_busy, div_done;
  logic [NUM_W-1:0] div_quot;
  logic             zero_q;
  logic [EFF_W-1:0] eff_q;

  // ---------------- measurement window ----------------
  assign trigger = run_i && (ar_valid_i || w_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= 1'b0;
    else if (clear_i) win_q <= 1'b0;
    else if (trigger) win_q <= 1'b1;
  end

  // ---------------- beat and cycle counters ----------------
  assign inc[IDX_WR] = run_i && w_valid_i && w_ready_i;
  assign inc[IDX_RD] = run_i && r_valid_i && r_ready_i;
  assign inc[IDX_CY] = run_i && (win_q || trigger);

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    perf_sat_cnt #(
      .W (CNT_W)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );
  end

  assign wr_beats_o = cnt[IDX_WR];
  assign rd_beats_o = cnt[IDX_RD];
  assign cycles_o   = cnt[IDX_CY];

  // ---------------- efficiency: multiply first, divide once ----------------
  assign beat_sum  = {1'b0, cnt[IDX_WR]} + {1'b0, cnt[IDX_RD]};
  assign div_num   = NUM_W'(beat_sum) * NUM_W'(SCALE);
  assign div_den   = DEN_W'(cnt[IDX_CY]) * DEN_W'(MEM_MHZ);
  assign div_start = !div_busy && !clear_i;

  perf_div #(
    .NUM_W (NUM_W),
    .DEN_W (DEN_W)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q <= 1'b1;
      eff_q  <= '0;
    end else if (clear_i) begin
      zero_q <= 1'b1;
      eff_q  <= '0;
    end else begin
      if (div_start) zero_q <= (cnt[IDX_CY] == '0);
      if (div_done) begin
        if (zero_q)                 eff_q <= '0;
        else if (div_quot > EFF_CAP) eff_q <= '1;
        else                        eff_q <= div_quot[EFF_W-1:0];
      end
    end
  end

  assign eff_pct_o = eff_q;

  // ---------------- read latency ----------------
  perf_lat_track #(
    .LAT_W (LAT_W),
    .DEPTH (FIFO_DEPTH)
  ) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clear_i),
    .en_i      (run_i),
    .ar_hs_i   (ar_valid_i && ar_ready_i),
    .r_valid_i (r_valid_i),
    .r_hs_i    (r_valid_i && r_ready_i),
    .min_lat_o (min_lat_o)
  );

  // ---------------- checks ----------------
  assert_wr_in_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_beats_o <= cycles_o);

  assert_closed_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_q && !trigger && !clear_i) |=> cycles_o == '0);

  assert_idle_eff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycles_o == '0 |-> eff_pct_o == '0);

  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (wr_beats_o == '0 && rd_beats_o == '0 && cycles_o == '0 &&
                 eff_pct_o == '0 && min_lat_o == '1));

  assert_paused_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> ($stable(wr_beats_o) && $stable(rd_beats_o) && $stable(cycles_o)));

endmodule

// File: tb/sim_axi_perf_mon.sv
`timescale 1ns/1ps
module sim_axi_perf_mon;

  localparam int unsigned CNT_W = 10;
  localparam int unsigned LAT_W = 8;
  localparam int unsigned EFF_W = 8;
  localparam int unsigned CORE  = 250;
  localparam int unsigned MEM   = 1000;
  localparam int unsigned CMAX  = (1 << CNT_W) - 1;
  localparam int unsigned LMAX  = (1 << LAT_W) - 1;
  localparam int unsigned SETTLE = 120;

  // lead idle cycles, active cycles, write period, read period (0 = none)
  localparam int unsigned N_VEC = 6;
  localparam int unsigned VEC [N_VEC][4] = '{
    '{3, 100, 1, 1},
    '{0, 100, 1, 0},
    '{5,  90, 2, 3},
    '{1,  64, 4, 4},
    '{2,  50, 3, 0},
    '{0,  77, 5, 7}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, run_i = 1'b0;
  logic ar_valid_i = 1'b0, ar_ready_i = 1'b0;
  logic w_valid_i = 1'b0, w_ready_i = 1'b0;
  logic r_valid_i = 1'b0, r_ready_i = 1'b0;
  logic [CNT_W-1:0] wr_beats_o, rd_beats_o, cycles_o;
  logic [EFF_W-1:0] eff_pct_o;
  logic [LAT_W-1:0] min_lat_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  axi_perf_mon #(
    .CNT_W      (CNT_W),
    .LAT_W      (LAT_W),
    .EFF_W      (EFF_W),
    .FIFO_DEPTH (8),
    .CORE_MHZ   (CORE),
    .MEM_MHZ    (MEM)
  ) u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .run_i      (run_i),
    .ar_valid_i (ar_valid_i),
    .ar_ready_i (ar_ready_i),
    .w_valid_i  (w_valid_i),
    .w_ready_i  (w_ready_i),
    .r_valid_i  (r_valid_i),
    .r_ready_i  (r_ready_i),
    .wr_beats_o (wr_beats_o),
    .rd_beats_o (rd_beats_o),
    .cycles_o   (cycles_o),
    .eff_pct_o  (eff_pct_o),
    .min_lat_o  (min_lat_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic bus_idle();
    ar_valid_i = 1'b0; ar_ready_i = 1'b0;
    w_valid_i  = 1'b0; w_ready_i  = 1'b0;
    r_valid_i  = 1'b0; r_ready_i  = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_clear();
    clear_i = 1'b1;
    step(1);
    clear_i = 1'b0;
  endtask

  task automatic ar_beat();
    bus_idle();
    ar_valid_i = 1'b1; ar_ready_i = 1'b1;
    step(1);
    bus_idle();
  endtask

  task automatic r_beat();
    bus_idle();
    r_valid_i = 1'b1; r_ready_i = 1'b1;
    step(1);
    bus_idle();
  endtask

  // one request with data offered 'lat' cycles after the address, held 'hold' cycles unaccepted
  task automatic one_read(input int lat, input int hold);
    ar_beat();
    step(lat - 1);
    repeat (hold) begin
      r_valid_i = 1'b1; r_ready_i = 1'b0;
      step(1);
    end
    r_beat();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);

    // reset state
    chk("R8 reset wr", wr_beats_o, 0);
    chk("R8 reset rd", rd_beats_o, 0);
    chk("R3 reset cycles", cycles_o, 0);
    chk("R4 reset eff", eff_pct_o, 0);
    chk("R6 reset min", min_lat_o, LMAX);

    // table of traffic mixes
    for (int v = 0; v < N_VEC; v++) begin
      int exp_w, exp_r, exp_e;
      exp_w = 0; exp_r = 0;
      pulse_clear();
      run_i = 1'b1;
      step(VEC[v][0]);
      for (int i = 0; i < VEC[v][1]; i++) begin
        w_valid_i = 1'b1;
        w_ready_i = (i % VEC[v][2]) == 0;
        r_valid_i = (VEC[v][3] != 0) && ((i % VEC[v][3]) == 0);
        r_ready_i = r_valid_i;
        if (w_ready_i) exp_w++;
        if (r_valid_i) exp_r++;
        step(1);
      end
      run_i = 1'b0;
      bus_idle();
      step(SETTLE);
      exp_e = ((exp_w + exp_r) * 200 * CORE) / (VEC[v][1] * MEM);
      chk("R1 table wr", wr_beats_o, exp_w);
      chk("R2 table rd", rd_beats_o, exp_r);
      chk("R3 table cycles", cycles_o, VEC[v][1]);
      chk("R4 table eff", eff_pct_o, exp_e);
    end

    // R3: read data alone does not open the window; a request does
    pulse_clear();
    run_i = 1'b1;
    r_valid_i = 1'b1; r_ready_i = 1'b1;
    step(5);
    bus_idle();
    chk("R3 rvalid no window", cycles_o, 0);
    chk("R2 rd before window", rd_beats_o, 5);
    ar_valid_i = 1'b1;
    step(1);
    bus_idle();
    step(3);
    chk("R3 window from first request", cycles_o, 4);

    // R10: paused monitor ignores traffic
    run_i = 1'b0;
    w_valid_i = 1'b1; w_ready_i = 1'b1;
    step(5);
    bus_idle();
    chk("R10 paused wr", wr_beats_o, 0);
    chk("R10 paused cycles", cycles_o, 4);
    one_read(1, 0);
    chk("R10 paused min", min_lat_o, LMAX);

    // R1: valid without ready does not count
    run_i = 1'b1;
    w_valid_i = 1'b1; w_ready_i = 1'b0;
    step(3);
    w_ready_i = 1'b1;
    step(3);
    bus_idle();
    chk("R1 only handshakes", wr_beats_o, 3);

    // R8: clear wins over a concurrent beat, window re-arms
    w_valid_i = 1'b1; w_ready_i = 1'b1;
    clear_i = 1'b1;
    step(1);
    clear_i = 1'b0;
    bus_idle();
    chk("R8 clear wr", wr_beats_o, 0);
    chk("R8 clear cycles", cycles_o, 0);
    chk("R8 clear eff", eff_pct_o, 0);
    step(3);
    chk("R8 window re-armed", cycles_o, 0);

    // R5 / R6: latency tracking
    pulse_clear();
    run_i = 1'b1;
    one_read(4, 1);
    chk("R5 first latency", min_lat_o, 4);
    chk("R2 held data counts once", rd_beats_o, 1);
    one_read(6, 0);
    chk("R6 larger keeps min", min_lat_o, 4);
    one_read(4, 0);
    chk("R6 equal keeps min", min_lat_o, 4);
    one_read(2, 0);
    chk("R6 smaller updates", min_lat_o, 2);

    // R7: ninth outstanding request is untracked, later ones realign
    pulse_clear();
    run_i = 1'b1;
    for (int k = 0; k < 8; k++) ar_beat();
    step(21);
    ar_beat();
    for (int k = 0; k < 9; k++) r_beat();
    chk("R7 overflow request ignored", min_lat_o, 30);
    one_read(5, 0);
    chk("R7 tracking realigned", min_lat_o, 5);

    // R9: saturation
    pulse_clear();
    run_i = 1'b1;
    w_valid_i = 1'b1; w_ready_i = 1'b1;
    step(CMAX + 80);
    run_i = 1'b0;
    bus_idle();
    step(SETTLE);
    chk("R9 wr saturates", wr_beats_o, CMAX);
    chk("R9 cycles saturate", cycles_o, CMAX);
    chk("R4 eff at saturation", eff_pct_o, 50);

    report();
  end

endmodule